// File: doc/BRIEF.md
# Serial Port Interrupt Identification Unit

This block sits between the status logic of a 16550-style serial port and the bus that services it. It holds the interrupt enable byte and gathers five interrupt conditions: receiver line-status events, received data present, receive character timeout, transmit holding register empty, and modem-status change events. It masks each one with its enable bit and reports the most urgent survivor as a four-bit code in an identification byte. Bit 0 of that byte is low while something is pending.

Line-status and modem-status events arrive as one-cycle pulses. They are latched until software reads the matching status register. The transmitter-empty condition is latched on its rising edge. It is dropped when software reads the identification byte while that byte reports it, or when the holding register fills again. For every latched source whose read drops it, a one-cycle clear strobe is returned. Received-data and timeout are level conditions, which their own source logic removes.

The interrupt line is the pending flag gated by a modem-control gate bit. The two top bits of the identification byte show whether the FIFOs are on.

Top module: `uart_irq_ident`

## Requirements
- R1: During and after reset the enable byte is 0x00, the identification byte is 0x01, the interrupt line is low and all clear strobes are low.
- R2: A write strobe loads the full enable byte, which appears on `ier_q` after the clock edge. Bit 0 enables received data, bit 1 transmitter empty, bit 2 line status, bit 3 modem status, bit 4 character timeout and bit 6 the whole unit. Bits 5 and 7 are only stored.
- R3: Bit 0 of the identification byte is 0 when a source is reported and 1 otherwise. Bits 3:0 read 0x6 for line status, 0xC for timeout, 0x4 for received data, 0x2 for transmitter empty, 0x0 for modem status and 0x1 for none. Bits 5:4 read 0.
- R4: When several enabled sources are pending, only one is reported, in this order: line status, timeout, received data, transmitter empty, modem status.
- R5: Bits 7:6 of the identification byte both equal `fifo_en`.
- R6: A source whose enable bit is 0 is never reported. While enable bit 6 is 0, nothing is reported.
- R7: `irq` is high exactly when a source is reported and `int_gate` is high.
- R8: A line or modem event pulse latches that source until a cycle in which its status register is read. The read clears it after the edge, and one cycle later the matching strobe pulses for one cycle. An event in the same cycle as the read wins, and no strobe is sent.
- R9: The transmitter-empty source is latched on a rising edge of `thr_empty`. An identification read while it is reported clears it and sends its strobe. It stays clear while `thr_empty` stays high. A low `thr_empty` also clears it, without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Enable byte write strobe |
| ier_wdata | input | 8 | Enable byte write data |
| rx_data_avail | input | 1 | Received data present (level) |
| rx_timeout | input | 1 | Receive character timeout (level) |
| line_evt | input | 1 | Line-status event pulse |
| modem_evt | input | 1 | Modem-status change pulse |
| thr_empty | input | 1 | Transmit holding register empty (level) |
| fifo_en | input | 1 | FIFOs enabled |
| int_gate | input | 1 | Modem-control interrupt gate bit |
| iir_rd | input | 1 | Identification byte read strobe |
| lsr_rd | input | 1 | Line-status register read strobe |
| msr_rd | input | 1 | Modem-status register read strobe |
| ier_q | output | 8 | Current enable byte |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Interrupt line, active high |
| clr_line | output | 1 | Clear strobe to line-status source |
| clr_modem | output | 1 | Clear strobe to modem-status source |
| clr_thre | output | 1 | Clear strobe to transmitter source |

## Verification
The hardest case to reach is a source that is latched but hidden, either by a higher-priority source or by its own clear enable bit. Its state can only be seen indirectly. The stimulus stacks all five sources and then peels them off one by one, checking that each hidden source appears in turn. It latches a modem event with its enable bit cleared, and proves the latch was set only through the clear strobe that the status read returns. A separate step drives a line event in the same cycle as a line-status read, to show that the event survives the read.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int IER_W     = 8;
  localparam int IER_RXD   = 0;
  localparam int IER_THRE  = 1;
  localparam int IER_LINE  = 2;
  localparam int IER_MODEM = 3;
  localparam int IER_TMO   = 4;
  localparam int IER_UNIT  = 6;

  typedef enum logic [3:0] {
    CODE_MODEM = 4'h0,
    CODE_THRE  = 4'h2,
    CODE_RXD   = 4'h4,
    CODE_LINE  = 4'h6,
    CODE_TMO   = 4'hC
  } irq_code_e;

  typedef struct packed {
    logic line;
    logic tmo;
    logic rxd;
    logic thre;
    logic modem;
  } irq_src_t;
endpackage

// File: rtl/uart_irq_enable.sv
module uart_irq_enable #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] ier_q
);
  logic [W-1:0] ier_d;

  always_comb begin
    ier_d = ier_q;
    if (wr_en) ier_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ier_q <= '0;
    else        ier_q <= ier_d;
  end

  assert_ier_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ier_q == $past(wr_data));
  assert_ier_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ier_q));
endmodule

// File: rtl/uart_irq_latch.sv
module uart_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic ack_req_i,
  output logic pend_o,
  output logic ack_o
);
  logic pend_d, ack_d;

  always_comb begin
    pend_d = set_i | (pend_o & ~clr_i);
    ack_d  = ack_req_i & pend_o & ~set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o <= 1'b0;
      ack_o  <= 1'b0;
    end else begin
      pend_o <= pend_d;
      ack_o  <= ack_d;
    end
  end

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_o);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !pend_o);
  assert_ack_needs_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(pend_o) && !pend_o);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  irq_src_t    req,
  input  logic        fifo_en,
  output logic        pend_o,
  output logic [3:0]  code_o,
  output logic [7:0]  iir_o
);
  irq_code_e code;

  always_comb begin
    pend_o = 1'b1;
    code   = CODE_MODEM;
    if      (req.line)  code = CODE_LINE;
    else if (req.tmo)   code = CODE_TMO;
    else if (req.rxd)   code = CODE_RXD;
    else if (req.thre)  code = CODE_THRE;
    else if (req.modem) code = CODE_MODEM;
    else                pend_o = 1'b0;
    code_o = code;
    iir_o  = {{2{fifo_en}}, 2'b00, code_o[3:1], ~pend_o};
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr,
  input  logic [IER_W-1:0] ier_wdata,
  input  logic             rx_data_avail,
  input  logic             rx_timeout,
  input  logic             line_evt,
  input  logic             modem_evt,
  input  logic             thr_empty,
  input  logic             fifo_en,
  input  logic             int_gate,
  input  logic             iir_rd,
  input  logic             lsr_rd,
  input  logic             msr_rd,
  output logic [IER_W-1:0] ier_q,
  output logic [7:0]       iir,
  output logic             irq,
  output logic             clr_line,
  output logic             clr_modem,
  output logic             clr_thre
);
  logic [1:0] rst_sync;
  logic       rst_int_n;
  logic       thr_q;
  logic       line_pend, modem_pend, thre_pend;
  logic       thre_set, thre_clr, thre_ack_req;
  logic       any_pend, unit_on;
  logic [3:0] code;
  irq_src_t   req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) thr_q <= 1'b0;
    else            thr_q <= thr_empty;
  end

  uart_irq_enable #(.W(IER_W)) u_ier (
    .clk(clk), .rst_n(rst_int_n), .wr_en(ier_wr), .wr_data(ier_wdata), .ier_q(ier_q)
  );

  uart_irq_latch u_line (
    .clk(clk), .rst_n(rst_int_n), .set_i(line_evt), .clr_i(lsr_rd),
    .ack_req_i(lsr_rd), .pend_o(line_pend), .ack_o(clr_line)
  );

  uart_irq_latch u_modem (
    .clk(clk), .rst_n(rst_int_n), .set_i(modem_evt), .clr_i(msr_rd),
    .ack_req_i(msr_rd), .pend_o(modem_pend), .ack_o(clr_modem)
  );

  always_comb begin
    thre_set     = thr_empty & ~thr_q;
    thre_ack_req = iir_rd & any_pend & (code == CODE_THRE);
    thre_clr     = thre_ack_req | ~thr_empty;
  end

  uart_irq_latch u_thre (
    .clk(clk), .rst_n(rst_int_n), .set_i(thre_set), .clr_i(thre_clr),
    .ack_req_i(thre_ack_req), .pend_o(thre_pend), .ack_o(clr_thre)
  );

  always_comb begin
    unit_on   = ier_q[IER_UNIT];
    req.line  = line_pend     & ier_q[IER_LINE]  & unit_on;
    req.tmo   = rx_timeout    & ier_q[IER_TMO]   & unit_on;
    req.rxd   = rx_data_avail & ier_q[IER_RXD]   & unit_on;
    req.thre  = thre_pend     & ier_q[IER_THRE]  & unit_on;
    req.modem = modem_pend    & ier_q[IER_MODEM] & unit_on;
  end

  uart_irq_prio u_prio (
    .req(req), .fifo_en(fifo_en), .pend_o(any_pend), .code_o(code), .iir_o(iir)
  );

  assign irq = any_pend & int_gate;

  assert_line_first_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (line_pend && ier_q[IER_LINE] && ier_q[IER_UNIT]) |-> iir[3:0] == 4'h6);
  assert_modem_masked_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ier_q[IER_MODEM] |-> iir[3:0] != 4'h0);
  assert_unit_off_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ier_q[IER_UNIT] |-> iir[0]);
  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq == (!iir[0] && int_gate));
  assert_fifo_bits_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    iir[7:6] == {2{fifo_en}} && iir[5:4] == 2'b00);
  assert_thre_read_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (iir_rd && iir[3:0] == 4'h2) |=> !thre_pend && clr_thre);
endmodule

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
  logic clk = 1'b0;
  logic rst_n;
  logic ier_wr;
  logic [7:0] ier_wdata;
  logic rx_data_avail, rx_timeout, line_evt, modem_evt, thr_empty;
  logic fifo_en, int_gate, iir_rd, lsr_rd, msr_rd;
  logic [7:0] ier_q, iir;
  logic irq, clr_line, clr_modem, clr_thre;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] iir;
    logic       irq;
    logic [2:0] ack;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  uart_irq_ident dut (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .rx_data_avail(rx_data_avail), .rx_timeout(rx_timeout), .line_evt(line_evt),
    .modem_evt(modem_evt), .thr_empty(thr_empty), .fifo_en(fifo_en),
    .int_gate(int_gate), .iir_rd(iir_rd), .lsr_rd(lsr_rd), .msr_rd(msr_rd),
    .ier_q(ier_q), .iir(iir), .irq(irq), .clr_line(clr_line),
    .clr_modem(clr_modem), .clr_thre(clr_thre)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: inputs were set at the preceding falling edge; one rising edge later
  // the expected outputs are handed to the scoreboard.
  task automatic step(input logic [7:0] e_iir, input logic e_irq,
                      input logic [2:0] e_ack, input string tag);
    exp_t e;
    @(posedge clk);
    #2;
    e.iir = e_iir; e.irq = e_irq; e.ack = e_ack; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    ier_wr = 0; line_evt = 0; modem_evt = 0; iir_rd = 0; lsr_rd = 0; msr_rd = 0;
  endtask

  // Monitor: compares after the edge's effects settle, before the next drive.
  always @(posedge clk) begin
    #3;
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check({8'h00, iir}, {8'h00, e.iir}, {e.tag, " iir"});
      check({15'h0, irq}, {15'h0, e.irq}, {e.tag, " irq"});
      check({13'h0, clr_thre, clr_modem, clr_line}, {13'h0, e.ack}, {e.tag, " strobes"});
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ier_wr = 0; ier_wdata = 0; rx_data_avail = 0; rx_timeout = 0;
    line_evt = 0; modem_evt = 0; thr_empty = 0; fifo_en = 0; int_gate = 1;
    iir_rd = 0; lsr_rd = 0; msr_rd = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({8'h0, ier_q}, 16'h0000, "R1 ier reset");
    check({8'h0, iir}, 16'h0001, "R1 iir reset");
    check({15'h0, irq}, 16'h0, "R1 irq reset");
    check({13'h0, clr_thre, clr_modem, clr_line}, 16'h0, "R1 strobes reset");
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R2 enable write: all sources plus unit enable
    ier_wr = 1; ier_wdata = 8'h5F;
    step(8'h01, 0, 3'b000, "R2 write idle");
    check({8'h0, ier_q}, 16'h005F, "R2 ier readback");

    // R3/R4: stack up sources in rising priority
    modem_evt = 1;
    step(8'h00, 1, 3'b000, "R3 modem code");
    thr_empty = 1;
    step(8'h02, 1, 3'b000, "R4 thre over modem");
    rx_data_avail = 1;
    step(8'h04, 1, 3'b000, "R4 rxd over thre");
    rx_timeout = 1;
    step(8'h0C, 1, 3'b000, "R4 timeout over rxd");
    line_evt = 1;
    step(8'h06, 1, 3'b000, "R4 line over all");

    // R8 line read clears, strobe next
    lsr_rd = 1;
    step(8'h0C, 1, 3'b001, "R8 line read");
    rx_timeout = 0;
    step(8'h04, 1, 3'b000, "R3 rxd code");
    rx_data_avail = 0;
    step(8'h02, 1, 3'b000, "R3 thre code");

    // R9 ident read while thre reported
    iir_rd = 1;
    step(8'h00, 1, 3'b100, "R9 thre read clear");
    step(8'h00, 1, 3'b000, "R9 stays clear");
    msr_rd = 1;
    step(8'h01, 0, 3'b010, "R8 modem read");
    thr_empty = 0;
    step(8'h01, 0, 3'b000, "R9 empty low");
    thr_empty = 1;
    step(8'h02, 1, 3'b000, "R9 rising edge");

    // R7 gate, R5 fifo bits
    int_gate = 0;
    step(8'h02, 0, 3'b000, "R7 gate off");
    int_gate = 1; fifo_en = 1;
    step(8'hC2, 1, 3'b000, "R5 fifo bits");

    // R6 masking
    ier_wr = 1; ier_wdata = 8'h5D;
    step(8'hC1, 0, 3'b000, "R6 thre masked");
    iir_rd = 1;
    step(8'hC1, 0, 3'b000, "R6 masked read keeps");
    ier_wr = 1; ier_wdata = 8'h5F;
    step(8'hC2, 1, 3'b000, "R6 thre unmasked");
    ier_wr = 1; ier_wdata = 8'h1F;
    step(8'hC1, 0, 3'b000, "R6 unit off");
    check({8'h0, ier_q}, 16'h001F, "R2 ier second value");
    ier_wr = 1; ier_wdata = 8'h5F;
    step(8'hC2, 1, 3'b000, "R6 unit on");
    iir_rd = 1;
    step(8'hC1, 0, 3'b100, "R9 read clears again");
    ier_wr = 1; ier_wdata = 8'h57; modem_evt = 1;
    step(8'hC1, 0, 3'b000, "R6 modem masked");
    msr_rd = 1;
    step(8'hC1, 0, 3'b010, "R8 masked modem was latched");

    // R8 event and read in the same cycle
    line_evt = 1; lsr_rd = 1;
    step(8'hC6, 1, 3'b000, "R8 event wins read");
    lsr_rd = 1;
    step(8'hC1, 0, 3'b001, "R8 line cleared");
    step(8'hC1, 0, 3'b000, "R8 strobe one cycle");

    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule